// File: doc/BRIEF.md
# Indexed Codec Control Register Port

This block is the host-facing control port of an audio codec. A byte-wide bus reaches four direct locations: an index pointer, a data window, a status byte and a programmed-I/O byte. Through the pointer and the window the host reads and writes a bank of thirty-two 8-bit indirect control registers. A mode bit in the bank selects whether the pointer decodes sixteen or thirty-two indirect registers.

The block enforces the write rules of the bank. The sample-format register only changes while a mode-change enable is active, fully or for the upper nibble only. Some locations are read-only or reserved, one register keeps a bit that is always zero, and another takes only its mode bit. The block also provides a one-shot calibration-busy indication armed when the mode-change enable is raised. It keeps an interrupt flag that a playback engine raises and the host acknowledges. The whole bank is presented on a flat output bus, and a strobe tells the playback engine that the sample format has been rewritten.

Top module: `ccr_port`

## Requirements
- R1: After reset the pointer reads 0x40 and the indirect registers hold 0x88 at indices 2 to 5, 18 and 19, 0x80 at 6 and 7, 0x08 at 9, 0x8A at 12, 0xA0 at 25 and 26, and zero elsewhere. The interrupt output and the format strobe are low.
- R2: Bus address 0 writes and reads the pointer. Bit 7 of a written byte is dropped and the pointer always reads bit 7 as 0. Bit 6 of the pointer is the mode-change enable (MCE).
- R3: Bus address 1 accesses the indirect register picked by pointer bits [3:0] while bit 6 of register 12 is 0, and by pointer bits [4:0] while it is 1.
- R4: A write to register 8 is taken whole while MCE is 1. While MCE is 0 and bit 4 of register 24 is 1, only bits [7:4] are taken and bits [3:0] keep their old value. Otherwise the write is dropped.
- R5: `fmt_update` is high for exactly the one cycle after a write that register 8 accepted, and the new value is visible in that cycle. It stays low after a dropped write.
- R6: Writes to registers 11, 22, 27 and 29 change nothing. A write to register 12 changes only its bit 6.
- R7: Bit 5 of register 9 is stored as 0 whatever is written.
- R8: A pointer write that takes MCE from 0 to 1 while bits [4:3] of register 9 are not both 0 loads the calibration count with 1. A data-window read of register 11 while the count is nonzero returns bit 5 set and decrements the count. Without such an arming event, bit 5 reads as the stored value.
- R9: A one-cycle `play_done` pulse sets status bit 0 and bit 4 (PI) of register 24, and `irq_o` is high from the next cycle on.
- R10: Any write to bus address 2 clears status bit 0 and bits 4, 5 and 6 of register 24, and drops `irq_o`.
- R11: A write to register 24 with bit 4 at 0, while bit 4 was 1, clears status bit 0 and drops `irq_o`.
- R12: When `play_done` and a status-port write fall in the same cycle, the new event wins: status bit 0, `irq_o` and bit 4 of register 24 end up set, and bits 5 and 6 of register 24 end up clear.
- R13: Writes to bus address 3 are ignored and it reads 0. Indirect registers without a special rule store all eight written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Direct location: 0 pointer, 1 data window, 2 status, 3 programmed-I/O |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe; needed for read side effects |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, combinational from address and state |
| play_done | input | 1 | Playback terminal-count event from the playback engine |
| irq_o | output | 1 | Interrupt request, follows status bit 0 |
| fmt_update | output | 1 | One-cycle pulse after an accepted sample-format write |
| ctl_regs | output | 256 | All indirect registers, register n at bits [8n+7:8n] |

## Verification
A playback completion event and the host acknowledge can land in the same clock. The event is raised by the playback side, and the acknowledge is either a status-port write or a register 24 write that clears PI. The bench drives `play_done` high in the very cycle it writes the status port, after seeding bits 5 and 6 of register 24. It then reads the status byte, register 24 and the interrupt line to confirm that the fresh event survived and the older flags were cleared. A second overlap is the arming of the calibration count by a pointer write and the later reads of register 11. The bench checks that exactly one read shows the busy bit.

// File: rtl/ccr_pkg.sv
`timescale 1ns/1ps
package ccr_pkg;

   localparam int BYTE_W = 8;

   // direct bus locations
   localparam logic [1:0] LOC_PTR  = 2'd0;
   localparam logic [1:0] LOC_WIN  = 2'd1;
   localparam logic [1:0] LOC_STAT = 2'd2;
   localparam logic [1:0] LOC_PIO  = 2'd3;

   // indirect registers with special behaviour
   localparam int IX_FMT   = 8;
   localparam int IX_CFG   = 9;
   localparam int IX_ERR   = 11;
   localparam int IX_MODE  = 12;
   localparam int IX_HOLE0 = 22;
   localparam int IX_FEAT  = 24;
   localparam int IX_HOLE1 = 27;
   localparam int IX_HOLE2 = 29;

   // bit positions
   localparam int B_MCE   = 6;   // pointer
   localparam int B_WIDE  = 6;   // register 12
   localparam int B_PMCE  = 4;   // register 24
   localparam int B_PI    = 4;   // register 24
   localparam int B_CI    = 5;
   localparam int B_TI    = 6;
   localparam int B_CAL   = 5;   // register 11 read
   localparam int B_RSV9  = 5;   // register 9

   typedef struct packed {
      logic                take;
      logic [BYTE_W-1:0]   val;
   } wr_res_t;

   function automatic logic [BYTE_W-1:0] reg_reset(input int ix);
      case (ix)
         2, 3, 4, 5, 18, 19: reg_reset = 8'h88;
         6, 7:               reg_reset = 8'h80;
         IX_CFG:             reg_reset = 8'h08;
         IX_MODE:            reg_reset = 8'h8A;
         25, 26:             reg_reset = 8'hA0;
         default:            reg_reset = 8'h00;
      endcase
   endfunction

   function automatic wr_res_t write_rule(input int ix,
                                          input logic [BYTE_W-1:0] old,
                                          input logic [BYTE_W-1:0] wd,
                                          input logic mce,
                                          input logic pmce);
      wr_res_t r;
      r.take = 1'b1;
      r.val  = wd;
      case (ix)
         IX_FMT: begin
            if (mce)       r.val = wd;
            else if (pmce) r.val = {wd[7:4], old[3:0]};
            else begin
               r.take = 1'b0;
               r.val  = old;
            end
         end
         IX_CFG:  r.val = {wd[7:6], 1'b0, wd[4:0]};
         IX_MODE: r.val = {old[7], wd[B_WIDE], old[5:0]};
         IX_ERR, IX_HOLE0, IX_HOLE1, IX_HOLE2: begin
            r.take = 1'b0;
            r.val  = old;
         end
         default: r.val = wd;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ccr_index.sv
`timescale 1ns/1ps
module ccr_index #(
   parameter int PTR_W    = 7,
   parameter int CAL_W    = 2,
   parameter int CAL_LOAD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_we,
   input  logic [7:0]       wdata,
   input  logic             cal_allow,
   input  logic             cal_take,
   output logic [PTR_W-1:0] ptr_q,
   output logic             cal_busy
);
   import ccr_pkg::*;

   localparam logic [PTR_W-1:0] PTR_RST = PTR_W'(1) << B_MCE;
   localparam logic [CAL_W-1:0] CAL_INIT = CAL_W'(CAL_LOAD);

   logic [CAL_W-1:0] cal_q;
   logic             arm;

   assign arm      = ptr_we && !ptr_q[B_MCE] && wdata[B_MCE] && cal_allow;
   assign cal_busy = (cal_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= PTR_RST;
         cal_q <= '0;
      end else begin
         if (ptr_we) ptr_q <= wdata[PTR_W-1:0];
         if (arm)
            cal_q <= CAL_INIT;
         else if (cal_take && cal_busy)
            cal_q <= cal_q - 1'b1;
      end
   end
endmodule

// File: rtl/ccr_bank.sv
`timescale 1ns/1ps
module ccr_bank #(
   parameter int NREG = 32,
   parameter int IX_W = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   win_we,
   input  logic [IX_W-1:0]        ix,
   input  logic [7:0]             wdata,
   input  logic                   mce,
   input  logic                   flag_set,
   input  logic                   flag_clr,
   output logic [NREG*8-1:0]      regs_flat,
   output logic                   fmt_pulse,
   output logic                   pi_drop
);
   import ccr_pkg::*;

   logic [7:0] cur [NREG];
   logic       fmt_take;

   genvar gi;
   generate
      for (gi = 0; gi < NREG; gi++) begin : g_reg
         wr_res_t    res;
         logic [7:0] nxt;
         logic       hit;

         assign hit = win_we && (ix == IX_W'(gi));

         always_comb begin
            res = write_rule(gi, cur[gi], wdata, mce, cur[IX_FEAT][B_PMCE]);
            nxt = cur[gi];
            if (hit && res.take) nxt = res.val;
            if (gi == IX_FEAT) begin
               if (flag_clr) begin
                  nxt[B_PI] = 1'b0;
                  nxt[B_CI] = 1'b0;
                  nxt[B_TI] = 1'b0;
               end
               if (flag_set) nxt[B_PI] = 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) cur[gi] <= reg_reset(gi);
            else        cur[gi] <= nxt;
         end

         assign regs_flat[gi*8 +: 8] = cur[gi];

         if (gi == IX_FMT) begin : g_fmt
            assign fmt_take = hit && res.take;
         end
      end
   endgenerate

   assign pi_drop = win_we && (ix == IX_W'(IX_FEAT)) &&
                    cur[IX_FEAT][B_PI] && !wdata[B_PI];

   always_ff @(posedge clk) begin
      if (!rst_n) fmt_pulse <= 1'b0;
      else        fmt_pulse <= fmt_take;
   end
endmodule

// File: rtl/ccr_irq.sv
`timescale 1ns/1ps
module ccr_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic event_in,
   input  logic ack_stat,
   input  logic ack_pi,
   output logic int_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)                    int_q <= 1'b0;
      else if (event_in)             int_q <= 1'b1;
      else if (ack_stat || ack_pi)   int_q <= 1'b0;
   end
endmodule

// File: rtl/ccr_port.sv
`timescale 1ns/1ps
module ccr_port #(
   parameter int NREG     = 32,
   parameter int CAL_W    = 2,
   parameter int CAL_LOAD = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_addr,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [7:0]        host_wdata,
   output logic [7:0]        host_rdata,
   input  logic              play_done,
   output logic              irq_o,
   output logic              fmt_update,
   output logic [NREG*8-1:0] ctl_regs
);
   import ccr_pkg::*;

   localparam int IX_W     = $clog2(NREG);
   localparam int PTR_W    = BYTE_W - 1;
   localparam int NARROW_W = IX_W - 1;

   generate
      if (NREG != 32) begin : g_bad_nreg
         $error("ccr_port: bank must hold 32 registers");
      end
      if (CAL_LOAD < 1 || CAL_LOAD >= (1 << CAL_W)) begin : g_bad_cal
         $error("ccr_port: CAL_LOAD does not fit CAL_W");
      end
   endgenerate

   logic [PTR_W-1:0] ptr_q;
   logic             cal_busy;
   logic             wide;
   logic [IX_W-1:0]  ix;
   logic             ptr_we, win_we, stat_we;
   logic             pi_drop, int_q;
   logic [7:0]       sel;

   assign ptr_we  = host_wr && (host_addr == LOC_PTR);
   assign win_we  = host_wr && (host_addr == LOC_WIN);
   assign stat_we = host_wr && (host_addr == LOC_STAT);

   assign wide = ctl_regs[IX_MODE*8 + B_WIDE];
   assign ix   = wide ? ptr_q[IX_W-1:0] : {1'b0, ptr_q[NARROW_W-1:0]};

   ccr_index #(.PTR_W(PTR_W), .CAL_W(CAL_W), .CAL_LOAD(CAL_LOAD)) u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr_we   (ptr_we),
      .wdata    (host_wdata),
      .cal_allow(ctl_regs[IX_CFG*8 + 3 +: 2] != 2'b00),
      .cal_take (host_rd && (host_addr == LOC_WIN) && (ix == IX_W'(IX_ERR))),
      .ptr_q    (ptr_q),
      .cal_busy (cal_busy)
   );

   ccr_bank #(.NREG(NREG), .IX_W(IX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .win_we   (win_we),
      .ix       (ix),
      .wdata    (host_wdata),
      .mce      (ptr_q[B_MCE]),
      .flag_set (play_done),
      .flag_clr (stat_we),
      .regs_flat(ctl_regs),
      .fmt_pulse(fmt_update),
      .pi_drop  (pi_drop)
   );

   ccr_irq u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .event_in(play_done),
      .ack_stat(stat_we),
      .ack_pi  (pi_drop),
      .int_q   (int_q)
   );

   assign irq_o = int_q;

   always_comb begin
      sel = ctl_regs[ix*8 +: 8];
      if (ix == IX_W'(IX_ERR) && cal_busy) sel[B_CAL] = 1'b1;
      case (host_addr)
         LOC_PTR:  host_rdata = {1'b0, ptr_q};
         LOC_WIN:  host_rdata = sel;
         LOC_STAT: host_rdata = {7'b0, int_q};
         default:  host_rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/ccr_port_chk.sv
`timescale 1ns/1ps
module ccr_port_chk #(
   parameter int NREG = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        host_addr,
   input logic              host_wr,
   input logic              host_rd,
   input logic [7:0]        host_rdata,
   input logic              play_done,
   input logic              irq_o,
   input logic              fmt_update,
   input logic [NREG*8-1:0] ctl_regs
);
   a_r2_ptr_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == 2'd0) |-> !host_rdata[7]);

   a_r5_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_update |-> $past(host_wr && host_addr == 2'd1));

   a_r6_err_reg_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ctl_regs[11*8 +: 8]));

   a_r6_holes_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ctl_regs[22*8 +: 8]) && $stable(ctl_regs[27*8 +: 8]) &&
      $stable(ctl_regs[29*8 +: 8]));

   a_r7_cfg_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_regs[9*8 + 5]);

   a_r9_event_raises: assert property (@(posedge clk) disable iff (!rst_n)
      play_done |=> irq_o);

   a_r10_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd2 && !play_done) |=> !irq_o);

   a_r12_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd2 && play_done) |=>
         (irq_o && ctl_regs[24*8 + 4] && !ctl_regs[24*8 + 5] && !ctl_regs[24*8 + 6]));
endmodule

bind ccr_port ccr_port_chk #(.NREG(NREG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_addr (host_addr),
   .host_wr   (host_wr),
   .host_rd   (host_rd),
   .host_rdata(host_rdata),
   .play_done (play_done),
   .irq_o     (irq_o),
   .fmt_update(fmt_update),
   .ctl_regs  (ctl_regs)
);

// File: tb/tb_ccr_port.sv
`timescale 1ns/1ps
module tb_ccr_port;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   host_addr = 2'd0;
   logic         host_wr = 1'b0;
   logic         host_rd = 1'b0;
   logic [7:0]   host_wdata = 8'h00;
   logic [7:0]   host_rdata;
   logic         play_done = 1'b0;
   logic         irq_o;
   logic         fmt_update;
   logic [255:0] ctl_regs;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic last_fmt;
   logic [7:0] rv;

   always #2.5 clk = ~clk;

   ccr_port dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .play_done(play_done), .irq_o(irq_o), .fmt_update(fmt_update),
      .ctl_regs(ctl_regs)
   );

   // {index, write byte, expected read-back}, wide mode active
   localparam logic [20:0] VEC [10] = '{
      {5'd0,  8'hA5, 8'hA5},
      {5'd9,  8'hFF, 8'hDF},
      {5'd11, 8'h55, 8'h00},
      {5'd12, 8'hFF, 8'hCA},
      {5'd22, 8'h77, 8'h00},
      {5'd27, 8'h66, 8'h00},
      {5'd29, 8'h44, 8'h00},
      {5'd16, 8'h3C, 8'h3C},
      {5'd31, 8'h81, 8'h81},
      {5'd25, 8'h12, 8'h12}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
      last_fmt = fmt_update;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic read_ix(input logic [7:0] ptr, output logic [7:0] d);
      bus_write(2'd0, ptr);
      bus_read(2'd1, d);
   endtask

   task automatic pulse_done();
      @(negedge clk);
      play_done = 1'b1;
      @(negedge clk);
      play_done = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      check("R1 irq", {7'b0, irq_o}, 8'h00);
      check("R1 fmt_update", {7'b0, fmt_update}, 8'h00);
      check("R1 reg25", ctl_regs[25*8 +: 8], 8'hA0);
      check("R1 reg26", ctl_regs[26*8 +: 8], 8'hA0);
      bus_read(2'd0, rv);  check("R1 pointer", rv, 8'h40);
      read_ix(8'h42, rv);  check("R1 reg2", rv, 8'h88);
      read_ix(8'h46, rv);  check("R1 reg6", rv, 8'h80);
      read_ix(8'h49, rv);  check("R1 reg9", rv, 8'h08);
      read_ix(8'h4C, rv);  check("R1 reg12", rv, 8'h8A);
      bus_read(2'd2, rv);  check("R1 status", rv, 8'h00);

      // R2 pointer bit 7
      bus_write(2'd0, 8'hC5);
      bus_read(2'd0, rv);  check("R2 pointer msb", rv, 8'h45);

      // R3 narrow then wide decode
      read_ix(8'h53, rv);  check("R3 narrow sees reg3", rv, 8'h88);
      bus_write(2'd1, 8'h11);
      check("R3 reg19 untouched", ctl_regs[19*8 +: 8], 8'h88);
      check("R3 reg3 written", ctl_regs[3*8 +: 8], 8'h11);
      bus_write(2'd0, 8'h4C);
      bus_write(2'd1, 8'h40);
      read_ix(8'h53, rv);  check("R3 wide sees reg19", rv, 8'h88);
      read_ix(8'h43, rv);  check("R3 wide sees reg3", rv, 8'h11);

      // table walk: R6, R7, R13
      for (int i = 0; i < 10; i++) begin
         bus_write(2'd0, {3'b000, VEC[i][20:16]});
         bus_write(2'd1, VEC[i][15:8]);
         bus_read(2'd1, rv);
         check($sformatf("R6/R7/R13 vector %0d", i), rv, VEC[i][7:0]);
      end

      // R4, R5 format gating and strobe
      bus_write(2'd0, 8'h48);
      bus_write(2'd1, 8'h5B);
      check("R5 strobe on full write", {7'b0, last_fmt}, 8'h01);
      check("R4 full write", ctl_regs[8*8 +: 8], 8'h5B);
      @(negedge clk);
      check("R5 strobe one cycle", {7'b0, fmt_update}, 8'h00);
      bus_write(2'd0, 8'h08);
      bus_write(2'd1, 8'hFF);
      check("R5 no strobe on drop", {7'b0, last_fmt}, 8'h00);
      bus_read(2'd1, rv);  check("R4 dropped write", rv, 8'h5B);
      bus_write(2'd0, 8'h58);
      bus_write(2'd1, 8'h10);
      bus_write(2'd0, 8'h08);
      bus_write(2'd1, 8'hA7);
      check("R5 strobe on nibble write", {7'b0, last_fmt}, 8'h01);
      bus_read(2'd1, rv);  check("R4 upper nibble only", rv, 8'hAB);
      bus_write(2'd0, 8'h58);
      bus_write(2'd1, 8'h00);

      // R8 calibration flag (reg9 bits 4:3 set from table)
      bus_write(2'd0, 8'h0B);
      bus_write(2'd0, 8'h4B);
      bus_read(2'd1, rv);  check("R8 first read busy", rv, 8'h20);
      bus_read(2'd1, rv);  check("R8 second read idle", rv, 8'h00);
      bus_write(2'd0, 8'h4B);
      bus_read(2'd1, rv);  check("R8 no rise no arm", rv, 8'h00);
      bus_write(2'd0, 8'h09);
      bus_write(2'd1, 8'h00);
      bus_write(2'd0, 8'h4B);
      bus_read(2'd1, rv);  check("R8 cfg zero no arm", rv, 8'h00);

      // R9 event
      bus_write(2'd0, 8'h58);
      pulse_done();
      check("R9 irq", {7'b0, irq_o}, 8'h01);
      bus_read(2'd2, rv);  check("R9 status", rv, 8'h01);
      bus_read(2'd1, rv);  check("R9 PI", rv, 8'h10);

      // R10 status acknowledge
      bus_write(2'd1, 8'h70);
      check("R11 PI kept keeps irq", {7'b0, irq_o}, 8'h01);
      bus_write(2'd2, 8'h00);
      check("R10 irq", {7'b0, irq_o}, 8'h00);
      bus_read(2'd2, rv);  check("R10 status", rv, 8'h00);
      bus_read(2'd1, rv);  check("R10 flags", rv, 8'h00);

      // R11 PI falling acknowledge
      pulse_done();
      bus_write(2'd1, 8'h00);
      check("R11 irq", {7'b0, irq_o}, 8'h00);
      bus_read(2'd2, rv);  check("R11 status", rv, 8'h00);

      // R12 same-cycle event and acknowledge
      bus_write(2'd1, 8'h60);
      @(negedge clk);
      host_addr = 2'd2; host_wdata = 8'h00; host_wr = 1'b1; play_done = 1'b1;
      @(negedge clk);
      host_wr = 1'b0; play_done = 1'b0;
      check("R12 irq", {7'b0, irq_o}, 8'h01);
      bus_read(2'd2, rv);  check("R12 status", rv, 8'h01);
      bus_read(2'd1, rv);  check("R12 flags", rv, 8'h10);

      // R13 programmed-I/O location
      bus_write(2'd3, 8'hFF);
      bus_read(2'd3, rv);  check("R13 pio read", rv, 8'h00);
      bus_read(2'd2, rv);  check("R13 status untouched", rv, 8'h01);
      bus_read(2'd0, rv);  check("R13 pointer untouched", rv, 8'h58);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule